// File: doc/BRIEF.md
# Rectangle Host-Pixel Writer

This block is a drawing engine that fills an axis-aligned rectangle of a frame buffer with pixels streamed from the host. Software programs three registers: a draw-mode word, a packed origin corner and a packed inclusive far corner. A command starts when software writes any of these registers through the execute alias, which is the same offset with address bit `GO_BIT` set. The written value is stored first, and the command then runs on the updated register contents.

While a command runs, the engine takes 32-bit host pixel words on a valid/ready stream in row-major order. For each accepted word it issues exactly one frame-buffer write. The write carries the current x/y position and the 24-bit colour held in the word. The frame buffer can stall a pending write. `busy` stays high from the launching register write until the write for the far corner has been taken.

Top module: `rect_host_blit`

## Requirements
- R1: During and right after reset, `busy`, `pix_ready` and `fb_we` are 0.
- R2: A register write with `reg_addr[GO_BIT]`=1 launches a command when all of the following hold after the write is stored: the mode has op field `reg_wdata[1:0]`=2 (fill), rectangle addressing `[4:2]`=1 and host colour `[6]`=1, and the far corner is at or beyond the origin on both axes. Register select is `reg_addr[3:2]`: 0 = mode, 1 = origin, 2 = far corner. A corner word carries x in bits `[16 +: COORD_W]` and y in bits `[0 +: COORD_W]`. `busy` and `pix_ready` are 1 in the cycle after the launching write.
- R3: An execute write whose stored state does not meet R2 is a no-operation. This covers an op field other than 2, an addressing field other than 1, host colour bit 0, and a far corner below the origin on either axis. `busy` stays 0 and no frame-buffer write occurs.
- R4: A register write with `reg_addr[GO_BIT]`=0 stores its value but does not start a command. A later execute write uses the stored values.
- R5: Each pixel accepted (`pix_valid && pix_ready` at a clock edge) produces `fb_we`=1 in the next cycle. Positions run x from origin to far x inclusive, then y+1. `fb_data` is pixel bits `[23:0]`, and bits `[31:24]` are dropped.
- R6: While `fb_we && fb_stall`, `pix_ready` is 0 and `fb_x`, `fb_y`, `fb_data` and `fb_we` hold into the next cycle.
- R7: `busy` falls only in the cycle after the final write is taken (`fb_we && !fb_stall`). Once the far-corner pixel has been accepted, `pix_ready` stays 0 and further host pixels produce no writes.
- R8: Register writes made while `busy` is 1 are ignored. The running rectangle is unchanged, and no command starts after it ends.
- R9: A one-pixel rectangle gives exactly one write. A rectangle whose far corner sits at the largest coordinate value completes without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address; bit GO_BIT selects the execute alias |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Command in progress |
| pix_valid | input | 1 | Host pixel word valid |
| pix_data | input | PIX_W | Host pixel word (RGB in low 24 bits) |
| pix_ready | output | 1 | Engine accepts a host pixel this cycle |
| fb_we | output | 1 | Frame-buffer write request |
| fb_x | output | COORD_W | Write x position |
| fb_y | output | COORD_W | Write y position |
| fb_data | output | RGB_W | Write colour |
| fb_stall | input | 1 | Frame buffer refuses the pending write |

## Verification
The bench builds the block with `COORD_W`=8 and all other parameters at their defaults. The narrow coordinate puts the top coordinate value 255 within reach, so a rectangle ending at the edge of the coordinate space is walked and shows that the inclusive end does not wrap. The bench also runs rectangles under periodic `fb_stall` and gaps in `pix_valid`. It issues execute writes in the middle of a command to show they have no effect.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    localparam int REG_DW  = 32;
    localparam int SEL_LSB = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_FILL  = 2'd2,
        OP_MOVE  = 2'd3
    } op_e;

    localparam logic [2:0] AM_RECT = 3'd1;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_ORIGIN = 2'd1,
        SEL_LIMIT  = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] amode;
        logic       host_src;
    } mode_t;

    function automatic logic mode_is_fill(input mode_t m);
        return (m.op == OP_FILL) && (m.amode == AM_RECT) && m.host_src;
    endfunction

endpackage

// File: rtl/rbw_regs.sv
module rbw_regs
    import rbw_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int REG_AW  = 12,
    parameter int GO_BIT  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic               launch,
    output logic [COORD_W-1:0] init_x,
    output logic [COORD_W-1:0] init_y,
    output logic [COORD_W-1:0] org_x,
    output logic [COORD_W-1:0] lim_x,
    output logic [COORD_W-1:0] lim_y
);
    localparam int HALF = REG_DW / 2;

    mode_t              mode_q, mode_n;
    logic [COORD_W-1:0] ox_q, oy_q, lx_q, ly_q;
    logic [COORD_W-1:0] ox_n, oy_n, lx_n, ly_n;
    logic               wr_ok, go_hit;
    sel_e               sel;
    mode_t              wd_mode;
    logic [COORD_W-1:0] wd_x, wd_y;
    logic               unused_bits;

    assign wr_ok   = reg_wr && !busy;
    assign go_hit  = reg_addr[GO_BIT];
    assign sel     = sel_e'(reg_addr[SEL_LSB +: 2]);
    assign wd_mode = '{op: op_e'(reg_wdata[1:0]), amode: reg_wdata[4:2], host_src: reg_wdata[6]};
    assign wd_x    = reg_wdata[HALF +: COORD_W];
    assign wd_y    = reg_wdata[0 +: COORD_W];
    assign unused_bits = ^{reg_addr, reg_wdata};

    always_comb begin
        mode_n = mode_q;
        ox_n   = ox_q;
        oy_n   = oy_q;
        lx_n   = lx_q;
        ly_n   = ly_q;
        if (wr_ok) begin
            case (sel)
                SEL_MODE:   mode_n = wd_mode;
                SEL_ORIGIN: begin ox_n = wd_x; oy_n = wd_y; end
                SEL_LIMIT:  begin lx_n = wd_x; ly_n = wd_y; end
                default:    ;
            endcase
        end
    end

    assign launch = wr_ok && go_hit && mode_is_fill(mode_n)
                    && (lx_n >= ox_n) && (ly_n >= oy_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{op: OP_IDLE, amode: 3'd0, host_src: 1'b0};
            ox_q   <= '0;
            oy_q   <= '0;
            lx_q   <= '0;
            ly_q   <= '0;
        end else begin
            mode_q <= mode_n;
            ox_q   <= ox_n;
            oy_q   <= oy_n;
            lx_q   <= lx_n;
            ly_q   <= ly_n;
        end
    end

    assign init_x = ox_n;
    assign init_y = oy_n;
    assign org_x  = ox_q;
    assign lim_x  = lx_q;
    assign lim_y  = ly_q;
endmodule

// File: rtl/rbw_walker.sv
module rbw_walker #(
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic [COORD_W-1:0] init_x,
    input  logic [COORD_W-1:0] init_y,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] lim_x,
    input  logic [COORD_W-1:0] lim_y,
    input  logic               step,
    output logic               active,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y
);
    logic row_end, col_end;

    assign row_end = (cur_x == lim_x);
    assign col_end = (cur_y == lim_y);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur_x  <= '0;
            cur_y  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            cur_x  <= init_x;
            cur_y  <= init_y;
        end else if (step && active) begin
            if (row_end) begin
                cur_x <= org_x;
                if (col_end) active <= 1'b0;
                else         cur_y  <= cur_y + COORD_W'(1);
            end else begin
                cur_x <= cur_x + COORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/rbw_fbout.sv
module rbw_fbout #(
    parameter int COORD_W = 16,
    parameter int PIX_W   = 32,
    parameter int RGB_W   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic               fb_stall,
    output logic               fb_we,
    output logic [COORD_W-1:0] fb_x,
    output logic [COORD_W-1:0] fb_y,
    output logic [RGB_W-1:0]   fb_data,
    output logic               hold
);
    logic unused_pad;

    assign hold       = fb_we && fb_stall;
    assign unused_pad = ^in_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_we   <= 1'b0;
            fb_x    <= '0;
            fb_y    <= '0;
            fb_data <= '0;
        end else if (!hold) begin
            fb_we <= load;
            if (load) begin
                fb_x    <= in_x;
                fb_y    <= in_y;
                fb_data <= in_pix[RGB_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rect_host_blit.sv
module rect_host_blit
    import rbw_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int PIX_W   = 32,
    parameter int RGB_W   = 24,
    parameter int REG_AW  = 12,
    parameter int GO_BIT  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic               busy,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_data,
    output logic               pix_ready,
    output logic               fb_we,
    output logic [COORD_W-1:0] fb_x,
    output logic [COORD_W-1:0] fb_y,
    output logic [RGB_W-1:0]   fb_data,
    input  logic               fb_stall
);
    logic               launch, active, hold, accept;
    logic [COORD_W-1:0] init_x, init_y, org_x, lim_x, lim_y, cur_x, cur_y;

    assign busy      = active || fb_we;
    assign pix_ready = active && !hold;
    assign accept    = pix_valid && pix_ready;

    rbw_regs #(.COORD_W(COORD_W), .REG_AW(REG_AW), .GO_BIT(GO_BIT)) i_regs (
        .clk(clk), .rst(rst), .busy(busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .launch(launch), .init_x(init_x), .init_y(init_y),
        .org_x(org_x), .lim_x(lim_x), .lim_y(lim_y)
    );

    rbw_walker #(.COORD_W(COORD_W)) i_walker (
        .clk(clk), .rst(rst), .launch(launch), .init_x(init_x), .init_y(init_y),
        .org_x(org_x), .lim_x(lim_x), .lim_y(lim_y), .step(accept),
        .active(active), .cur_x(cur_x), .cur_y(cur_y)
    );

    rbw_fbout #(.COORD_W(COORD_W), .PIX_W(PIX_W), .RGB_W(RGB_W)) i_fbout (
        .clk(clk), .rst(rst), .load(accept), .in_x(cur_x), .in_y(cur_y),
        .in_pix(pix_data), .fb_stall(fb_stall), .fb_we(fb_we), .fb_x(fb_x),
        .fb_y(fb_y), .fb_data(fb_data), .hold(hold)
    );
endmodule

// File: rtl/rect_host_blit_chk.sv
module rect_host_blit_chk #(
    parameter int COORD_W = 16,
    parameter int RGB_W   = 24,
    parameter int REG_AW  = 12,
    parameter int GO_BIT  = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               busy,
    input logic               pix_valid,
    input logic               pix_ready,
    input logic               fb_we,
    input logic [COORD_W-1:0] fb_x,
    input logic [COORD_W-1:0] fb_y,
    input logic [RGB_W-1:0]   fb_data,
    input logic               fb_stall
);
    logic go_wr, mode_nofill_go, unused_chk;

    assign go_wr          = reg_wr && reg_addr[GO_BIT];
    assign mode_nofill_go = go_wr && (reg_addr[3:2] == 2'd0) && (reg_wdata[1:0] != 2'd2);
    assign unused_chk     = ^{reg_addr, reg_wdata};

    p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go_wr));

    p_nop_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_nofill_go) |=> !busy);

    p_plain_no_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go_wr) |=> !busy);

    p_accept_emits_r5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready) |=> fb_we);

    p_hold_outputs_r6: assert property (@(posedge clk) disable iff (rst)
        (fb_we && fb_stall) |=> (fb_we && $stable(fb_x) && $stable(fb_y) && $stable(fb_data)));

    p_hold_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (fb_we && fb_stall) |-> !pix_ready);

    p_ready_in_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> busy);

    p_finish_write_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fb_we && !fb_stall));
endmodule

bind rect_host_blit rect_host_blit_chk #(
    .COORD_W(COORD_W), .RGB_W(RGB_W), .REG_AW(REG_AW), .GO_BIT(GO_BIT)
) i_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .pix_valid(pix_valid), .pix_ready(pix_ready), .fb_we(fb_we),
    .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data), .fb_stall(fb_stall)
);

// File: tb/test_rect_host_blit.sv
module test_rect_host_blit;
    localparam int CW = 8;
    localparam logic [11:0] A_MODE = 12'h000;
    localparam logic [11:0] A_ORG  = 12'h004;
    localparam logic [11:0] A_LIM  = 12'h008;
    localparam logic [11:0] GO     = 12'h800;
    localparam logic [31:0] M_FILL = 32'h0000_0046;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          busy;
    logic          pix_valid = 1'b0;
    logic [31:0]   pix_data = '0;
    logic          pix_ready;
    logic          fb_we;
    logic [CW-1:0] fb_x, fb_y;
    logic [23:0]   fb_data;
    logic          fb_stall = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [2*CW+23:0] exp_q[$];
    logic stall_en = 1'b0;
    logic gap_en   = 1'b0;
    int   cyc      = 0;
    logic hold_seen = 1'b0;
    logic [CW-1:0] hx, hy;
    logic [23:0] hd;

    always #2 clk = ~clk;

    rect_host_blit #(.COORD_W(CW)) i_rect_host_blit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .fb_we(fb_we), .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data), .fb_stall(fb_stall)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // stall source
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        fb_stall = stall_en && (cyc % 3 == 1);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_seen) chk("R6 hold", {fb_we, fb_x, fb_y, fb_data}, {1'b1, hx, hy, hd});
            hold_seen = fb_we && fb_stall;
            hx = fb_x; hy = fb_y; hd = fb_data;
            if (fb_we && fb_stall) chk("R6 ready low", pix_ready, 0);
            if (fb_we && !fb_stall) begin
                if (exp_q.size() == 0) chk("R5 unexpected write", {fb_x, fb_y, fb_data}, 0);
                else chk("R5 write", {fb_x, fb_y, fb_data}, exp_q.pop_front());
            end
        end
    end

    function automatic logic [31:0] pk(input int x, input int y);
        return (32'(x) << 16) | 32'(y);
    endfunction

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic send_pix(input logic [31:0] d);
        logic acc;
        pix_valid = 1'b1; pix_data = d;
        do begin
            @(negedge clk); acc = pix_ready;
            @(posedge clk); #1;
        end while (!acc);
        pix_valid = 1'b0;
    endtask

    task automatic send_part(input int xs, input int ys, input int xe, input int ye,
                             input int first, input int last, input int base);
        int k = 0;
        for (int y = ys; y <= ye; y++) begin
            for (int x = xs; x <= xe; x++) begin
                if (k >= first && k <= last) begin
                    logic [31:0] d;
                    d = {8'(k * 37 + 5), 24'(base + k * 32'h030507)};
                    exp_q.push_back({CW'(x), CW'(y), d[23:0]});
                    if (gap_en && (k % 4 == 2)) begin @(posedge clk); #1; end
                    send_pix(d);
                end
                k++;
            end
        end
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk({req, " busy clears"}, busy, 0);
        chk({req, " all writes seen"}, exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic launch(input int xs, input int ys, input int xe, input int ye);
        reg_write(A_ORG, pk(xs, ys));
        reg_write(A_LIM, pk(xe, ye));
        reg_write(GO | A_MODE, M_FILL);
        @(negedge clk);
        chk("R2 busy after go", busy, 1);
        chk("R2 ready after go", pix_ready, 1);
        @(posedge clk); #1;
    endtask

    task automatic expect_nop(input string req, input logic [11:0] a, input logic [31:0] d);
        reg_write(a, d);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req, {busy, pix_ready, fb_we}, 0);
        end
        @(posedge clk); #1;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {busy, pix_ready, fb_we}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {busy, pix_ready, fb_we}, 0);
        @(posedge clk); #1;

        // R4: plain writes store, no start
        reg_write(A_ORG, pk(2, 3));
        reg_write(A_LIM, pk(5, 4));
        reg_write(A_MODE, M_FILL);
        @(negedge clk);
        chk("R4 plain writes no start", busy, 0);
        @(posedge clk); #1;
        reg_write(GO | A_MODE, M_FILL);
        @(negedge clk);
        chk("R4 go uses stored state", busy, 1);
        @(posedge clk); #1;
        send_part(2, 3, 5, 4, 0, 7, 32'h102030);
        wait_idle("R5 4x2");

        // R6: stalls and input gaps
        stall_en = 1'b1; gap_en = 1'b1;
        launch(7, 1, 9, 3);
        send_part(7, 1, 9, 3, 0, 8, 32'h405060);
        wait_idle("R6 3x3 stalled");

        // R9: single pixel and max coordinate
        launch(40, 41, 40, 41);
        send_part(40, 41, 40, 41, 0, 0, 32'hABCDEF);
        wait_idle("R9 single");
        launch(253, 254, 255, 255);
        send_part(253, 254, 255, 255, 0, 5, 32'h0F0F0F);
        wait_idle("R9 edge");
        stall_en = 1'b0; gap_en = 1'b0;

        // R3: no-op commands
        reg_write(A_ORG, pk(1, 1));
        reg_write(A_LIM, pk(2, 2));
        expect_nop("R3 read op", GO | A_MODE, 32'h45);
        expect_nop("R3 copy op", GO | A_MODE, 32'h47);
        expect_nop("R3 span addressing", GO | A_MODE, 32'h42);
        expect_nop("R3 internal colour", GO | A_MODE, 32'h06);
        reg_write(A_MODE, M_FILL);
        reg_write(A_ORG, pk(5, 5));
        expect_nop("R3 x inverted", GO | A_LIM, pk(4, 9));
        expect_nop("R3 y inverted", GO | A_LIM, pk(9, 4));

        // R8: writes during busy ignored
        launch(10, 20, 13, 22);
        send_part(10, 20, 13, 22, 0, 4, 32'h777000);
        reg_write(GO | A_ORG, pk(0, 0));
        reg_write(GO | A_LIM, pk(1, 1));
        @(negedge clk);
        chk("R8 still busy", busy, 1);
        @(posedge clk); #1;
        send_part(10, 20, 13, 22, 5, 11, 32'h777000);
        wait_idle("R8 rect unchanged");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 no deferred start", busy, 0);
        end
        @(posedge clk); #1;

        // R7: extra pixels after the last one are ignored
        launch(3, 3, 4, 3);
        send_part(3, 3, 4, 3, 0, 1, 32'h123456);
        pix_valid = 1'b1; pix_data = 32'hDEADBEEF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 ready low after last", pix_ready, 0);
            @(posedge clk); #1;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 extra ignored", {busy, fb_we}, 0);
        end
        pix_valid = 1'b0;
        chk("R7 queue empty", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule